// File: doc/BRIEF.md
# Key Matrix Scanner and Packer

This block scans a keyboard matrix of twelve drive lines by four return inputs. It drives one scan line at a time, holding each for a fixed window of clock cycles. Near the end of each window it samples the four return inputs into a working key image. The scan lines leave the block as plain one-hot levels, because the segment drivers share those pins elsewhere.

The scan block that owns display timing gives two signals. The first is an enable that stops scanning while the display is forced off. The second is a one-cycle strobe at the end of every display frame. A full key-scan cycle lasts two frames. On the strobe that closes the second frame, the working image is copied as a whole into a readable image. A reader therefore never sees rows from two different scan cycles mixed together.

The serial decoder reads the readable image one byte at a time through a byte index. Each byte holds one odd-numbered line in its low nibble and the following even-numbered line in its high nibble. The decoder shifts each byte out from bit 0. After the last bit of one byte it moves to the next index.

Top module: `key_matrix_scanner`

## Requirements
- R1: After a synchronous reset with `scan_en` low, `scan_out` is all zero and every readable byte (index 0 to 5) reads 8'h00.
- R2: While `scan_en` is high, exactly one `scan_out` bit is high. Bit 0 (line 1) is high in the cycle enable rises. Each line is held for WIN_CYCLES clocks, the lines advance in ascending order, and line 12 wraps to line 1.
- R3: The return inputs are captured in the last clock of each line's window and stored as that line's row. `key_in[0]` is return K1 and `key_in[3]` is K4.
- R4: Readable byte i has the row of line 2i+1 in bits 3:0 and the row of line 2i+2 in bits 7:4, with K1 in the lowest bit of each nibble. For example, K1 on line 1 together with K4 on line 2 reads 8'h81 at index 0.
- R5: Counting `frame_end` pulses from the moment `scan_en` rises, only every second pulse copies the working image into the readable image. The first pulse of each pair leaves the readable bytes unchanged.
- R6: Between two copies the readable bytes do not change, even when the keys change. A copy replaces all six bytes in the same clock.
- R7: While `scan_en` is low, `scan_out` is all zero, `frame_end` has no effect on the readable bytes, and the frame pairing is cleared. When `scan_en` rises again, scanning restarts at line 1 and the next pulse is the first of a new pair.
- R8: A byte index of 6 or 7 reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_en | input | 1 | Scanning allowed; low while the display is forced off |
| frame_end | input | 1 | One-cycle strobe at the end of each display frame |
| key_in | input | 4 | Return inputs K1..K4, already synchronous to clk |
| rd_idx | input | 3 | Index of the readable byte (0..5 valid) |
| scan_out | output | 12 | One-hot scan line drive, bit 0 is line 1 |
| rd_byte | output | 8 | Packed byte selected by rd_idx |

## Verification
The assertions assume these things about the inputs:
- `frame_end` is a single-cycle pulse.
- `key_in` is already synchronous to the clock.
- `rd_idx` is always driven to a known value.

Under those assumptions they state the following:
- `scan_out` is one-hot and rotates through the lines.
- `scan_out` is zero whenever scanning is disabled.
- The readable bytes hold still unless a strobe arrived or the index moved.
- Indices past the last byte read zero.

The stimulus keeps within these assumptions. It changes every input at the falling clock edge and raises `frame_end` for exactly one cycle. A behavioural keyboard model derives `key_in` from the line currently driven on `scan_out`. Before any strobe that should latch, the stimulus waits long enough that all twelve windows have been sampled with the current key pattern.

// File: rtl/kms_pkg.sv
// Package: shared types for the key matrix scanner.
// Assumes nothing beyond being compiled before the modules that import it.
package kms_pkg;

    // Position inside the two-frame key-scan cycle
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } kms_phase_e;

endpackage

// File: rtl/kms_line_seq.sv
// Scan line sequencer: holds each scan line for WIN_CYCLES clocks, steps the
// lines in ascending order and wraps. It flags the last clock of every window
// as the sample point.
// Assumes scan_en is synchronous; the sequence restarts at line 1 whenever
// scan_en is low.
module kms_line_seq #(
    parameter int N_LINES    = 12,
    parameter int WIN_CYCLES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scan_en,
    output logic [$clog2(N_LINES)-1:0] line_idx,
    output logic                       sample_now,
    output logic [N_LINES-1:0]         scan_out
);
    localparam int LW = $clog2(N_LINES);
    localparam int CW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;

    logic [CW-1:0] win_cnt;
    logic          win_last;

    assign win_last   = (win_cnt == CW'(WIN_CYCLES - 1));
    assign sample_now = scan_en && win_last;

    // Advance the window counter and the active line
    always_ff @(posedge clk) begin
        if (!rst_n || !scan_en) begin
            win_cnt  <= '0;
            line_idx <= '0;
        end else if (win_last) begin
            win_cnt  <= '0;
            line_idx <= (line_idx == LW'(N_LINES - 1)) ? '0 : line_idx + 1'b1;
        end else begin
            win_cnt  <= win_cnt + 1'b1;
        end
    end

    // Decode the active line into one-hot drive levels
    for (genvar g = 0; g < N_LINES; g++) begin : g_drive
        assign scan_out[g] = scan_en && (line_idx == LW'(g));
    end

endmodule

// File: rtl/kms_sampler.sv
// Key image sampler: stores the return inputs as one row per scan line in a
// working image. On every second frame strobe of a scan cycle it copies the
// working image into the readable image in a single clock.
// Assumes frame_end is a one-cycle pulse and key_in is already synchronous.
module kms_sampler
    import kms_pkg::*;
#(
    parameter int N_LINES = 12,
    parameter int N_RET   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scan_en,
    input  logic                       frame_end,
    input  logic                       sample_now,
    input  logic [$clog2(N_LINES)-1:0] line_idx,
    input  logic [N_RET-1:0]           key_in,
    output logic [N_LINES*N_RET-1:0]   image_flat
);
    logic [N_LINES-1:0][N_RET-1:0] work_img;
    logic [N_LINES-1:0][N_RET-1:0] shadow_img;
    kms_phase_e                    phase;

    // Capture the active line's returns at the end of its window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_img <= '0;
        end else if (sample_now) begin
            work_img[line_idx] <= key_in;
        end
    end

    // Track frame pairs and publish the image on the closing strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_img <= '0;
            phase      <= PH_FIRST;
        end else if (!scan_en) begin
            phase      <= PH_FIRST;
        end else if (frame_end) begin
            if (phase == PH_SECOND) begin
                shadow_img <= work_img;
                phase      <= PH_FIRST;
            end else begin
                phase      <= PH_SECOND;
            end
        end
    end

    assign image_flat = shadow_img;

endmodule

// File: rtl/kms_packer.sv
// Byte packer: splits the readable image into bytes. Each byte holds two
// consecutive lines, the lower-numbered line in the low nibble. An index past
// the last byte selects zero.
// Assumes N_LINES is even and the image is flat with line 1 in the low bits.
module kms_packer #(
    parameter int N_LINES = 12,
    parameter int N_RET   = 4
) (
    input  logic [N_LINES*N_RET-1:0]     image_flat,
    input  logic [$clog2(N_LINES/2)-1:0] rd_idx,
    output logic [2*N_RET-1:0]           rd_byte
);
    localparam int BYTE_W  = 2 * N_RET;
    localparam int N_BYTES = N_LINES / 2;
    localparam int IW      = $clog2(N_BYTES);

    logic [BYTE_W-1:0] bytes [N_BYTES];

    // Slice each pair of rows into one byte
    for (genvar b = 0; b < N_BYTES; b++) begin : g_pack
        assign bytes[b] = {image_flat[(2*b+1)*N_RET +: N_RET],
                           image_flat[(2*b)*N_RET   +: N_RET]};
    end

    // Select the requested byte, zero when out of range
    always_comb begin
        rd_byte = '0;
        for (int b = 0; b < N_BYTES; b++) begin
            if ({1'b0, rd_idx} == (IW+1)'(b)) begin
                rd_byte = bytes[b];
            end
        end
    end

endmodule

// File: rtl/key_matrix_scanner.sv
// Key matrix scanner top: connects the line sequencer, the sampler with its
// two-frame publish and the byte packer.
// Assumes frame_end and scan_en come from the display timing block in the same
// clock domain, and that N_LINES is even.
module key_matrix_scanner #(
    parameter int N_LINES    = 12,
    parameter int N_RET      = 4,
    parameter int WIN_CYCLES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scan_en,
    input  logic                         frame_end,
    input  logic [N_RET-1:0]             key_in,
    input  logic [$clog2(N_LINES/2)-1:0] rd_idx,
    output logic [N_LINES-1:0]           scan_out,
    output logic [2*N_RET-1:0]           rd_byte
);
    localparam int LW = $clog2(N_LINES);

    logic [LW-1:0]              line_idx;
    logic                       sample_now;
    logic [N_LINES*N_RET-1:0]   image_flat;

    kms_line_seq #(
        .N_LINES    (N_LINES),
        .WIN_CYCLES (WIN_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_en    (scan_en),
        .line_idx   (line_idx),
        .sample_now (sample_now),
        .scan_out   (scan_out)
    );

    kms_sampler #(
        .N_LINES    (N_LINES),
        .N_RET      (N_RET)
    ) u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_en    (scan_en),
        .frame_end  (frame_end),
        .sample_now (sample_now),
        .line_idx   (line_idx),
        .key_in     (key_in),
        .image_flat (image_flat)
    );

    kms_packer #(
        .N_LINES    (N_LINES),
        .N_RET      (N_RET)
    ) u_pack (
        .image_flat (image_flat),
        .rd_idx     (rd_idx),
        .rd_byte    (rd_byte)
    );

endmodule

// File: rtl/kms_checker.sv
// Checker for the key matrix scanner: observes the top-level ports only and is
// attached with the bind below.
// Assumes frame_end is a one-cycle pulse and rd_idx is always known.
module kms_checker #(
    parameter int N_LINES = 12,
    parameter int N_RET   = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         scan_en,
    input logic                         frame_end,
    input logic [$clog2(N_LINES/2)-1:0] rd_idx,
    input logic [N_LINES-1:0]           scan_out,
    input logic [2*N_RET-1:0]           rd_byte
);
    localparam int N_BYTES = N_LINES / 2;
    localparam int IW      = $clog2(N_BYTES);

    // R2: never more than one line driven
    assert_one_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(scan_out));

    // R2: while enabled exactly one line is driven
    assert_line_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> ($countones(scan_out) == 1));

    // R2: a change of line moves to the next line, wrapping at the top
    assert_line_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && $past(scan_en) && (scan_out != $past(scan_out)))
        |-> (scan_out == {$past(scan_out[N_LINES-2:0]), $past(scan_out[N_LINES-1])}));

    // R7: halted scanning drives no line
    assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |-> (scan_out == '0));

    // R6: readable byte holds unless a strobe came or the index moved
    assert_image_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ((rd_idx != $past(rd_idx)) || $stable(rd_byte)));

    // R8: indices past the last byte read zero
    assert_range_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rd_idx} >= (IW+1)'(N_BYTES)) |-> (rd_byte == '0));

endmodule

bind key_matrix_scanner kms_checker #(
    .N_LINES (N_LINES),
    .N_RET   (N_RET)
) u_kms_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_en   (scan_en),
    .frame_end (frame_end),
    .rd_idx    (rd_idx),
    .scan_out  (scan_out),
    .rd_byte   (rd_byte)
);

// File: tb/tb_key_matrix_scanner.sv
// Directed bench for the key matrix scanner; a keyboard model answers the
// driven scan line with the pressed keys of that line.
module tb_key_matrix_scanner;
    localparam int NL  = 12;
    localparam int NR  = 4;
    localparam int WIN = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            scan_en = 1'b0;
    logic            frame_end = 1'b0;
    logic [NR-1:0]   key_in;
    logic [2:0]      rd_idx = 3'd0;
    logic [NL-1:0]   scan_out;
    logic [7:0]      rd_byte;

    logic [NL-1:0][NR-1:0] pressed = '0;
    logic [NL-1:0][NR-1:0] exp_img = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    key_matrix_scanner #(.N_LINES(NL), .N_RET(NR), .WIN_CYCLES(WIN)) dut (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .frame_end(frame_end),
        .key_in(key_in), .rd_idx(rd_idx), .scan_out(scan_out), .rd_byte(rd_byte)
    );

    // Keyboard model: returns the pressed keys of every driven line
    always_comb begin
        key_in = '0;
        for (int l = 0; l < NL; l++) begin
            if (scan_out[l]) key_in = key_in | pressed[l];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int i);
        return {exp_img[2*i+1], exp_img[2*i]};
    endfunction

    task automatic check_bytes(input string req);
        for (int i = 0; i < NL/2; i++) begin
            rd_idx = 3'(i);
            #1;
            chk(req, 32'(rd_byte), 32'(exp_byte(i)));
        end
    endtask

    task automatic pulse_frame();
        @(negedge clk) frame_end = 1'b1;
        @(negedge clk) frame_end = 1'b0;
    endtask

    task automatic wait_pass();
        repeat (WIN*NL + WIN) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; scan_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 scan_out idle", 32'(scan_out), 32'd0);
        exp_img = '0;
        check_bytes("R1 bytes cleared");
    endtask

    task automatic t_scan_order();
        @(negedge clk) scan_en = 1'b1;
        #1;
        for (int k = 0; k < 2*NL*WIN; k++) begin
            chk("R2 line order", 32'(scan_out), 32'(1) << ((k / WIN) % NL));
            @(negedge clk);
            #1;
        end
    endtask

    task automatic t_latch_pair();
        pressed = '0;
        pressed[0]  = 4'b0001;
        pressed[1]  = 4'b1000;
        pressed[11] = 4'b0100;
        wait_pass();
        pulse_frame();
        check_bytes("R5 first pulse no copy");
        pulse_frame();
        exp_img = pressed;
        rd_idx = 3'd0; #1;
        chk("R3 R4 byte0 literal", 32'(rd_byte), 32'h81);
        rd_idx = 3'd5; #1;
        chk("R3 R4 byte5 literal", 32'(rd_byte), 32'h40);
        check_bytes("R5 second pulse copies");
    endtask

    task automatic t_pattern(input logic [NL-1:0][NR-1:0] pat);
        pressed = pat;
        wait_pass();
        pulse_frame();
        pulse_frame();
        exp_img = pressed;
        check_bytes("R4 packing pattern");
    endtask

    task automatic t_atomic();
        pressed = {NL{4'b1010}};
        wait_pass();
        pulse_frame();
        check_bytes("R6 hold after first pulse");
        pressed = {NL{4'b0110}};
        wait_pass();
        check_bytes("R6 hold while keys change");
        pulse_frame();
        exp_img = pressed;
        check_bytes("R6 whole image replaced");
    endtask

    task automatic t_halt();
        pressed = {NL{4'b1111}};
        wait_pass();
        pulse_frame();
        @(negedge clk) scan_en = 1'b0;
        #1;
        chk("R7 no drive when halted", 32'(scan_out), 32'd0);
        pulse_frame();
        pulse_frame();
        check_bytes("R7 strobe ignored while halted");
        @(negedge clk) scan_en = 1'b1;
        #1;
        chk("R7 restart at line 1", 32'(scan_out), 32'd1);
        pressed = {NL{4'b0011}};
        wait_pass();
        pulse_frame();
        check_bytes("R7 pairing restarted");
        pulse_frame();
        exp_img = pressed;
        check_bytes("R7 copy after new pair");
    endtask

    task automatic t_range();
        rd_idx = 3'd6; #1;
        chk("R8 index 6 zero", 32'(rd_byte), 32'd0);
        rd_idx = 3'd7; #1;
        chk("R8 index 7 zero", 32'(rd_byte), 32'd0);
        rd_idx = 3'd0;
    endtask

    initial begin
        t_reset();
        t_scan_order();
        t_latch_pair();
        t_pattern({4'h5, 4'hA, 4'h3, 4'hC, 4'h9, 4'h6, 4'h1, 4'h2, 4'h4, 4'h8, 4'hF, 4'h0});
        t_pattern({4'hE, 4'h7, 4'hB, 4'hD, 4'h0, 4'hF, 4'h8, 4'h4, 4'h2, 4'h1, 4'h6, 4'h9});
        t_atomic();
        t_halt();
        t_range();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired, requirements R1 to R8 incomplete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule